// File: doc/BRIEF.md
# Analog Test Bus Interface Controller

This block is the digital control logic that decides how two external analog test pins are tied to two internal analog measurement buses during mixed-signal boundary-scan test. It is clocked by the test clock. It receives the instruction that the test access port has decoded, a select line for its own 4-bit control register, and the capture, shift and update strobes of the data-register path. From these it picks one of ten switch patterns (P0 to P9) and presents the choice as a registered one-hot enable vector. The analog switch network uses that vector to set its switches.

The pattern comes from two lookups. The instruction decides which family of patterns is allowed, and the scanned control word picks one pattern inside that family. New control bits are shifted into a separate stage and reach the active word only on an update strobe, so the switches never see partial values while a word is being shifted in. The same register captures the 1-bit digitized levels of both test pins, which lets an interconnect test read back what arrived at the pins.

Under the clamp instruction the active pattern is held at its present value. Under the high-impedance instruction the pins are isolated. When the interconnect patterns are active, the block also states which fixed levels the two pins are driven to. An asynchronous test reset clears everything. The release of that reset is synchronized to the test clock.

Top module: `atbic_ctrl`

## Requirements
- R1: While `trst_n` is low, `sw_en` equals 10'b00_0000_0001 (P0) at once, without waiting for a clock edge, and the active control word is cleared to 0. After release, a later EXTEST with no new update selects P0.
- R2: When `sel_ctl` and `shift_dr` are both high, each rising `tck` shifts the register right by one: `tdi` enters bit 3, and `tdo` always shows bit 0. A word therefore goes in least-significant bit first.
- R3: When `sel_ctl` and `capture_dr` are both high, a rising `tck` loads bit 0 with `at1_dig`, bit 1 with `at2_dig`, and bits 3:2 with 0. A pin level above threshold reads as 1.
- R4: The active control word takes the shift-stage value only on a rising `tck` with `sel_ctl` and `update_dr` both high. Shifting, or an update while `sel_ctl` is low, leaves `sw_en` unchanged.
- R5: For EXTEST (code 4'h0) and RUNBIST (code 4'h6), control words 0 to 7 select P0 to P7, word 9 selects P8, word 10 selects P9, and words 8 and 11 to 15 select P0.
- R6: For PROBE (code 4'h7) and INTEST (code 4'h8), control words 0 to 3 select P0 to P3, and every other word selects P0.
- R7: BYPASS (4'hF), SAMPLE (4'h1), PRELOAD (4'h2), IDCODE (4'h3), USERCODE (4'h4), HIGHZ (4'h9) and every unassigned code (4'hA to 4'hE) select P0, whatever the control word.
- R8: While the instruction is CLAMP (code 4'h5), `sw_en` holds the value it had when CLAMP became current. This holds even if a new control word is updated meanwhile. That word takes effect once a non-CLAMP instruction is current again.
- R9: In patterns P4 to P7, `at_drv_en` is 1 and `at_drv_lvl` = {AT1 level, AT2 level} equals 00, 01, 10 and 11 respectively. In any other pattern both outputs are 0.
- R10: Exactly one bit of `sw_en` is set, bit k meaning Pk. It changes one `tck` edge after the instruction or the active control word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| instr | input | 4 | Current decoded instruction code |
| sel_ctl | input | 1 | Control register is the selected data register |
| capture_dr | input | 1 | Capture strobe of the data-register path |
| shift_dr | input | 1 | Shift strobe of the data-register path |
| update_dr | input | 1 | Update strobe of the data-register path |
| tdi | input | 1 | Serial scan input |
| at1_dig | input | 1 | Digitized level of test pin 1 (1 when above threshold) |
| at2_dig | input | 1 | Digitized level of test pin 2 (1 when above threshold) |
| tdo | output | 1 | Serial scan output (bit 0 of shift stage) |
| sw_en | output | 10 | One-hot switch pattern enable, bit k = Pk |
| at_drv_en | output | 1 | Test pins are driven with fixed digital levels |
| at_drv_lvl | output | 2 | Driven levels, bit 1 = AT1, bit 0 = AT2 |

## Verification
The checker watches on every cycle that `sw_en` stays one-hot and that it holds still under CLAMP. It also checks that the isolation-only instructions, and PROBE with a word outside its range, land on P0 one edge later. It checks that the active word moves only on a selected update, and that the pin-drive levels agree with the chosen pattern. Other behaviours only the bench's scenarios can show. These are the complete word-to-pattern map of every instruction family, and the bit order of shifting and capture as seen on `tdo`. They also include a word loaded during CLAMP taking effect only after CLAMP ends, and the asynchronous effect of reset in the middle of a cycle.

// File: rtl/atbic_pkg.sv
package atbic_pkg;
  localparam int CTL_W = 4;
  localparam int INS_W = 4;
  localparam int NPAT  = 10;
  localparam int PAT_W = $clog2(NPAT);

  // instruction codes
  localparam logic [INS_W-1:0] I_EXTEST   = 4'h0;
  localparam logic [INS_W-1:0] I_SAMPLE   = 4'h1;
  localparam logic [INS_W-1:0] I_PRELOAD  = 4'h2;
  localparam logic [INS_W-1:0] I_IDCODE   = 4'h3;
  localparam logic [INS_W-1:0] I_USERCODE = 4'h4;
  localparam logic [INS_W-1:0] I_CLAMP    = 4'h5;
  localparam logic [INS_W-1:0] I_RUNBIST  = 4'h6;
  localparam logic [INS_W-1:0] I_PROBE    = 4'h7;
  localparam logic [INS_W-1:0] I_INTEST   = 4'h8;
  localparam logic [INS_W-1:0] I_HIGHZ    = 4'h9;
  localparam logic [INS_W-1:0] I_BYPASS   = 4'hF;

  // pattern families
  typedef enum logic [1:0] {
    FAM_ISOLATE = 2'd0,
    FAM_FULL    = 2'd1,
    FAM_MEASURE = 2'd2
  } fam_e;

  localparam int P_ISO      = 0;
  localparam int P_DRV_LO   = 4;
  localparam int P_DRV_HI   = 7;
  localparam int MEAS_LAST  = 3;
endpackage

// File: rtl/atbic_rst_sync.sv
module atbic_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/atbic_scan_reg.sv
module atbic_scan_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         capture,
  input  logic         shift,
  input  logic         update,
  input  logic         tdi,
  input  logic [W-1:0] cap_val,
  output logic         tdo,
  output logic [W-1:0] word
);
  logic [W-1:0] sh_q, sh_d;
  logic [W-1:0] act_q, act_d;
  logic         sh_en, act_en;

  always_comb begin
    sh_en  = sel && (capture || shift);
    act_en = sel && update;
    sh_d   = capture ? cap_val : {tdi, sh_q[W-1:1]};
    act_d  = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= '0;
    else if (act_en) act_q <= act_d;
  end

  assign tdo  = sh_q[0];
  assign word = act_q;
endmodule

// File: rtl/atbic_pattern_dec.sv
module atbic_pattern_dec
  import atbic_pkg::*;
(
  input  logic [INS_W-1:0] instr,
  input  logic [CTL_W-1:0] word,
  output logic [PAT_W-1:0] pat
);
  fam_e fam;

  always_comb begin
    case (instr)
      I_EXTEST, I_CLAMP, I_RUNBIST: fam = FAM_FULL;
      I_PROBE, I_INTEST:            fam = FAM_MEASURE;
      default:                      fam = FAM_ISOLATE;
    endcase
  end

  always_comb begin
    pat = PAT_W'(P_ISO);
    case (fam)
      FAM_FULL: begin
        if (word <= CTL_W'(P_DRV_HI)) pat = PAT_W'(word);
        else if (word == 4'd9)        pat = PAT_W'(8);
        else if (word == 4'd10)       pat = PAT_W'(9);
        else                          pat = PAT_W'(P_ISO);
      end
      FAM_MEASURE: begin
        if (word <= CTL_W'(MEAS_LAST)) pat = PAT_W'(word);
        else                           pat = PAT_W'(P_ISO);
      end
      default: pat = PAT_W'(P_ISO);
    endcase
  end
endmodule

// File: rtl/atbic_ctrl.sv
module atbic_ctrl
  import atbic_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic [INS_W-1:0] instr,
  input  logic             sel_ctl,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             tdi,
  input  logic             at1_dig,
  input  logic             at2_dig,
  output logic             tdo,
  output logic [NPAT-1:0]  sw_en,
  output logic             at_drv_en,
  output logic [1:0]       at_drv_lvl
);
  logic             rst_n_s;
  logic [CTL_W-1:0] ctl_word;
  logic [CTL_W-1:0] cap_val;
  logic [PAT_W-1:0] dec_pat;
  logic [PAT_W-1:0] pat_q, pat_d;
  logic             hold;

  atbic_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (tck),
    .arst_n (trst_n),
    .rst_n  (rst_n_s)
  );

  assign cap_val = {{(CTL_W-2){1'b0}}, at2_dig, at1_dig};

  atbic_scan_reg #(.W(CTL_W)) u_scan (
    .clk     (tck),
    .rst_n   (rst_n_s),
    .sel     (sel_ctl),
    .capture (capture_dr),
    .shift   (shift_dr),
    .update  (update_dr),
    .tdi     (tdi),
    .cap_val (cap_val),
    .tdo     (tdo),
    .word    (ctl_word)
  );

  atbic_pattern_dec u_dec (
    .instr (instr),
    .word  (ctl_word),
    .pat   (dec_pat)
  );

  always_comb begin
    hold  = (instr == I_CLAMP);
    pat_d = hold ? pat_q : dec_pat;
  end

  always_ff @(posedge tck or negedge rst_n_s) begin
    if (!rst_n_s) pat_q <= PAT_W'(P_ISO);
    else          pat_q <= pat_d;
  end

  for (genvar k = 0; k < NPAT; k++) begin : g_onehot
    assign sw_en[k] = (pat_q == PAT_W'(k));
  end

  always_comb begin
    at_drv_en  = (pat_q >= PAT_W'(P_DRV_LO)) && (pat_q <= PAT_W'(P_DRV_HI));
    at_drv_lvl = at_drv_en ? 2'(pat_q - PAT_W'(P_DRV_LO)) : 2'b00;
  end
endmodule

// File: rtl/atbic_ctrl_chk.sv
module atbic_ctrl_chk
  import atbic_pkg::*;
(
  input logic             tck,
  input logic             rst_n_s,
  input logic [INS_W-1:0] instr,
  input logic             sel_ctl,
  input logic             update_dr,
  input logic [CTL_W-1:0] ctl_word,
  input logic [NPAT-1:0]  sw_en,
  input logic             at_drv_en,
  input logic [1:0]       at_drv_lvl
);
  assert_onehot_R10: assert property (@(posedge tck) disable iff (!rst_n_s)
    $countones(sw_en) == 1);

  assert_clamp_hold_R8: assert property (@(posedge tck) disable iff (!rst_n_s)
    (instr == I_CLAMP) |=> $stable(sw_en));

  assert_isolate_R7: assert property (@(posedge tck) disable iff (!rst_n_s)
    (instr == I_HIGHZ || instr == I_BYPASS || instr == I_SAMPLE) |=> sw_en[0]);

  assert_probe_range_R6: assert property (@(posedge tck) disable iff (!rst_n_s)
    (instr == I_PROBE && ctl_word > 4'd3) |=> sw_en[0]);

  assert_update_only_R4: assert property (@(posedge tck) disable iff (!rst_n_s)
    !(sel_ctl && update_dr) |=> $stable(ctl_word));

  assert_reserved_word_R5: assert property (@(posedge tck) disable iff (!rst_n_s)
    (instr == I_EXTEST && ctl_word == 4'd8) |=> sw_en[0]);

  assert_drive_match_R9: assert property (@(posedge tck) disable iff (!rst_n_s)
    at_drv_en |-> sw_en[P_DRV_LO + int'(at_drv_lvl)]);

  assert_drive_idle_R9: assert property (@(posedge tck) disable iff (!rst_n_s)
    !at_drv_en |-> (at_drv_lvl == 2'b00));
endmodule

bind atbic_ctrl atbic_ctrl_chk u_chk (
  .tck        (tck),
  .rst_n_s    (rst_n_s),
  .instr      (instr),
  .sel_ctl    (sel_ctl),
  .update_dr  (update_dr),
  .ctl_word   (ctl_word),
  .sw_en      (sw_en),
  .at_drv_en  (at_drv_en),
  .at_drv_lvl (at_drv_lvl)
);

// File: tb/atbic_ctrl_tb.sv
module atbic_ctrl_tb;
  import atbic_pkg::*;

  logic             tck = 1'b0;
  logic             trst_n;
  logic [INS_W-1:0] instr;
  logic             sel_ctl, capture_dr, shift_dr, update_dr, tdi;
  logic             at1_dig, at2_dig;
  logic             tdo;
  logic [NPAT-1:0]  sw_en;
  logic             at_drv_en;
  logic [1:0]       at_drv_lvl;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 tck = ~tck;

  atbic_ctrl u_dut (
    .tck(tck), .trst_n(trst_n), .instr(instr), .sel_ctl(sel_ctl),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .at1_dig(at1_dig), .at2_dig(at2_dig), .tdo(tdo),
    .sw_en(sw_en), .at_drv_en(at_drv_en), .at_drv_lvl(at_drv_lvl)
  );

  // {instr, word, expected pattern}
  localparam int NV = 24;
  localparam logic [11:0] VEC [NV] = '{
    {I_EXTEST, 4'd0, 4'd0},  {I_EXTEST, 4'd1, 4'd1},  {I_EXTEST, 4'd2, 4'd2},
    {I_EXTEST, 4'd3, 4'd3},  {I_EXTEST, 4'd4, 4'd4},  {I_EXTEST, 4'd5, 4'd5},
    {I_EXTEST, 4'd6, 4'd6},  {I_EXTEST, 4'd7, 4'd7},  {I_EXTEST, 4'd8, 4'd0},
    {I_EXTEST, 4'd9, 4'd8},  {I_EXTEST, 4'd10, 4'd9}, {I_EXTEST, 4'd11, 4'd0},
    {I_EXTEST, 4'd15, 4'd0}, {I_RUNBIST, 4'd10, 4'd9}, {I_RUNBIST, 4'd6, 4'd6},
    {I_PROBE, 4'd3, 4'd3},   {I_PROBE, 4'd4, 4'd0},   {I_INTEST, 4'd1, 4'd1},
    {I_INTEST, 4'd9, 4'd0},  {I_BYPASS, 4'd5, 4'd0},  {I_SAMPLE, 4'd9, 4'd0},
    {I_HIGHZ, 4'd7, 4'd0},   {4'hC, 4'd7, 4'd0},      {I_USERCODE, 4'd3, 4'd0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge tck);
    @(negedge tck);
  endtask

  task automatic shift_in(input logic [3:0] w);
    for (int i = 0; i < 4; i++) begin
      sel_ctl = 1'b1; shift_dr = 1'b1; tdi = w[i];
      cyc();
    end
    shift_dr = 1'b0; tdi = 1'b0;
  endtask

  task automatic load_word(input logic [3:0] w);
    shift_in(w);
    update_dr = 1'b1;
    cyc();
    update_dr = 1'b0;
    cyc();
  endtask

  function automatic int pat_of(input logic [NPAT-1:0] v);
    for (int k = 0; k < NPAT; k++) if (v == (NPAT'(1) << k)) return k;
    return -1;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    trst_n = 1'b0; instr = I_BYPASS; sel_ctl = 1'b0; capture_dr = 1'b0;
    shift_dr = 1'b0; update_dr = 1'b0; tdi = 1'b0; at1_dig = 1'b0; at2_dig = 1'b0;
    repeat (3) cyc();
    chk("R1", "sw_en in reset", pat_of(sw_en), 0);
    chk("R1", "tdo in reset", int'(tdo), 0);
    trst_n = 1'b1;
    repeat (4) cyc();

    // table walk: R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      logic [3:0] ins, wd, ep;
      {ins, wd, ep} = VEC[i];
      instr = ins;
      load_word(wd);
      if (ins == I_EXTEST || ins == I_RUNBIST)
        chk("R5", "pattern full family", pat_of(sw_en), int'(ep));
      else if (ins == I_PROBE || ins == I_INTEST)
        chk("R6", "pattern measure family", pat_of(sw_en), int'(ep));
      else
        chk("R7", "pattern isolate family", pat_of(sw_en), int'(ep));
      chk("R9", "drive enable", int'(at_drv_en), int'(ep >= 4 && ep <= 7));
      chk("R9", "drive level", int'(at_drv_lvl), (ep >= 4 && ep <= 7) ? int'(ep) - 4 : 0);
    end

    // capture and shift-out order: R3 R2
    instr = I_EXTEST; at1_dig = 1'b1; at2_dig = 1'b0;
    sel_ctl = 1'b1; capture_dr = 1'b1;
    cyc();
    capture_dr = 1'b0;
    chk("R3", "tdo after capture (AT1)", int'(tdo), 1);
    shift_dr = 1'b1; tdi = 1'b1;
    cyc();
    chk("R2", "tdo after 1 shift (AT2)", int'(tdo), 0);
    cyc();
    chk("R3", "tdo after 2 shifts (bit2 zero)", int'(tdo), 0);
    cyc();
    chk("R3", "tdo after 3 shifts (bit3 zero)", int'(tdo), 0);
    cyc();
    chk("R2", "tdo after 4 shifts (tdi bit)", int'(tdo), 1);
    shift_dr = 1'b0; tdi = 1'b0;

    // update gating: R4
    load_word(4'd2);
    chk("R4", "baseline P2", pat_of(sw_en), 2);
    shift_in(4'd5);
    cyc();
    chk("R4", "shift without update", pat_of(sw_en), 2);
    sel_ctl = 1'b0; update_dr = 1'b1;
    cyc();
    update_dr = 1'b0;
    cyc();
    chk("R4", "update while unselected", pat_of(sw_en), 2);
    sel_ctl = 1'b1;

    // clamp hold: R8 R10
    load_word(4'd5);
    chk("R8", "before clamp P5", pat_of(sw_en), 5);
    instr = I_CLAMP;
    cyc();
    chk("R8", "entering clamp", pat_of(sw_en), 5);
    load_word(4'd2);
    cyc();
    chk("R8", "new word under clamp", pat_of(sw_en), 5);
    instr = I_EXTEST;
    cyc();
    chk("R10", "after clamp, one edge", pat_of(sw_en), 2);

    // highz isolates: R7
    instr = I_HIGHZ;
    cyc();
    chk("R7", "highz forces P0", pat_of(sw_en), 0);

    // async reset mid-cycle: R1
    instr = I_EXTEST;
    load_word(4'd6);
    chk("R1", "before reset P6", pat_of(sw_en), 6);
    @(posedge tck); #3;
    trst_n = 1'b0;
    #1;
    chk("R1", "async reset P0", pat_of(sw_en), 0);
    @(negedge tck);
    trst_n = 1'b1;
    repeat (4) cyc();
    chk("R1", "word cleared after reset", pat_of(sw_en), 0);
    chk("R9", "no drive after reset", int'(at_drv_en), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule